// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block produces all refresh traffic for an asynchronous DRAM whose refresh row counter lives inside the device. It does not generate addresses. After reset it waits out the power-up pause. It then runs a fixed number of CAS-before-RAS (CBR) warm-up cycles and raises a ready flag. From then on it earns one refresh credit per refresh interval. It spends those credits as CBR cycles whenever the access controller grants it the strobe pins.

When the controller holds the bus, credits pile up to a ceiling. They are then paid back in one back-to-back run once the grant returns. A four-phase sleep handshake moves the device into and out of self refresh:

- On entry, a full burst of every row runs immediately before the long RAS/CAS-low hold.
- On exit, the precharge-length pause comes first, followed by another full burst.

The acknowledge rises only once the hold has lasted long enough to count as a true entry. It falls only after the exit burst has completed. All timing is counted in clock cycles through parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: For INIT_WAIT cycles after reset, ras_n and cas_n stay high, bus_req stays low and init_done stays low.
- R2: After the pause, exactly INIT_CYCLES CBR cycles are issued, and then init_done rises and remains high.
- R3: In every CBR cycle, cas_n falls T_CSR cycles before ras_n falls and stays low for T_CHR cycles after it. ras_n stays low for T_RAS cycles, and we_n is high when ras_n falls.
- R4: Between the end of one CBR cycle (ras_n rising) and the cas_n fall of the next, ras_n stays high for at least T_RP cycles.
- R5: A CBR cycle begins (cas_n falls with ras_n high) only while both bus_req and bus_grant are high. No cycle begins while bus_grant is low.
- R6: After init_done, one refresh credit is earned every REF_INTERVAL cycles. With the grant held, the number of CBR cycles over N intervals is N give or take one.
- R7: While bus_grant is low, owed refreshes are retained up to MAX_PEND and bus_req stays high. When the grant returns they are issued back to back, and then bus_req falls.
- R8: When sleep_req is seen with the scheduler idle, exactly ROWS CBR cycles run. The self-refresh hold follows at once: ras_n falls T_RP+T_CSR cycles after the last burst cycle's ras_n rise, with cas_n leading by T_CSR.
- R9: In self refresh, ras_n and cas_n stay low together. sleep_ack rises SELF_HOLD cycles after ras_n falls, while both are still low. The hold lasts more than SELF_HOLD cycles even if sleep_req drops early.
- R10: On exit, ras_n and cas_n rise together and stay high for at least T_RPS cycles before the next cas_n fall. Exactly ROWS CBR cycles follow, and then sleep_ack falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_grant | input | 1 | Access controller lets this block drive the strobes |
| sleep_req | input | 1 | Request to enter (high) or leave (low) self refresh |
| bus_req | output | 1 | Block wants the strobe pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Power-up sequence complete |
| sleep_ack | output | 1 | Device is in self refresh (high) or still finishing exit (high) |

## Verification
The hardest case to reach is a sleep request that is withdrawn only a few cycles after the strobes have gone low. A careless design would release them before the minimum hold has elapsed. The stimulus first watches the strobe pins until the entry burst has completed and both strobes are low. It then drops sleep_req almost at once. The monitor then measures the low time and the exit precharge. Credit saturation is reached by withholding the grant for well over MAX_PEND intervals and counting the cycles that follow.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [3:0] {
        S_PWR_WAIT,
        S_INIT_REF,
        S_IDLE,
        S_REF,
        S_PRE_BURST,
        S_SELF_ENTER,
        S_SELF,
        S_SELF_EXIT,
        S_POST_BURST
    } sched_st_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HOLD,
        PH_ACT,
        PH_PRE
    } cbr_ph_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine
    import drs_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_CHR = 2,
    parameter int T_RAS = 4,
    parameter int T_RP  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic done,
    output logic ras_n,
    output logic cas_n
);

    localparam int LEN_MAX = max_of(max_of(T_CSR, T_CHR), max_of(T_RAS, T_RP));
    localparam int CW      = $clog2(LEN_MAX + 1);

    typedef struct packed {
        cbr_ph_e       ph;
        logic [CW-1:0] cnt;
    } eng_t;

    eng_t q, d;

    function automatic int ph_len(input cbr_ph_e p);
        case (p)
            PH_SETUP: return T_CSR;
            PH_HOLD:  return T_CHR;
            PH_ACT:   return T_RAS - T_CHR;
            PH_PRE:   return T_RP;
            default:  return 1;
        endcase
    endfunction

    logic last;

    always_comb begin
        d    = q;
        done = 1'b0;
        last = (q.cnt == CW'(ph_len(q.ph) - 1));
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph  = PH_SETUP;
                    d.cnt = '0;
                end
            end
            PH_SETUP, PH_HOLD, PH_ACT: begin
                if (last) begin
                    d.cnt = '0;
                    d.ph  = (q.ph == PH_SETUP) ? PH_HOLD :
                            (q.ph == PH_HOLD)  ? PH_ACT  : PH_PRE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_PRE: begin
                if (last) begin
                    d.ph  = PH_IDLE;
                    d.cnt = '0;
                    done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d = '{ph: PH_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, cnt: '0};
        else        q <= d;
    end

    assign idle  = (q.ph == PH_IDLE);
    assign cas_n = !(q.ph == PH_SETUP || q.ph == PH_HOLD);
    assign ras_n = !(q.ph == PH_HOLD || q.ph == PH_ACT);

endmodule

// File: rtl/drs_ref_timer.sv
module drs_ref_timer
    import drs_pkg::*;
#(
    parameter int INTERVAL = 100,
    parameter int MAX_PEND = 8,
    parameter int PW       = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clear,
    input  logic          served,
    output logic [PW-1:0] pend,
    output logic          pend_any
);

    localparam int IW = max_of(1, $clog2(INTERVAL));

    typedef struct packed {
        logic [IW-1:0] tcnt;
        logic [PW-1:0] pend;
    } tmr_t;

    tmr_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = en && (q.tcnt == IW'(INTERVAL - 1));
        if (clear) begin
            d.tcnt = '0;
            d.pend = '0;
        end else begin
            if (en) d.tcnt = tick ? '0 : q.tcnt + 1'b1;
            case ({tick, served})
                2'b10: if (q.pend != PW'(MAX_PEND)) d.pend = q.pend + 1'b1;
                2'b01: if (q.pend != '0)            d.pend = q.pend - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tcnt: '0, pend: '0};
        else        q <= d;
    end

    assign pend     = q.pend;
    assign pend_any = (q.pend != '0);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int INIT_WAIT    = 200,
    parameter int INIT_CYCLES  = 8,
    parameter int ROWS         = 16,
    parameter int REF_INTERVAL = 100,
    parameter int MAX_PEND     = 8,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 2,
    parameter int T_RAS        = 4,
    parameter int T_RP         = 3,
    parameter int SELF_HOLD    = 60,
    parameter int T_RPS        = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_grant,
    input  logic sleep_req,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic sleep_ack
);

    localparam int CNT_TOP = max_of(max_of(max_of(INIT_WAIT, SELF_HOLD), max_of(ROWS, INIT_CYCLES)),
                                    max_of(T_CSR, T_RPS));
    localparam int CW = $clog2(CNT_TOP + 1);
    localparam int PW = $clog2(MAX_PEND + 1);

    typedef struct packed {
        sched_st_e     st;
        logic [CW-1:0] cnt;
        logic          ready;
        logic          ack;
    } sched_t;

    localparam sched_t RST = '{st: S_PWR_WAIT, cnt: '0, ready: 1'b0, ack: 1'b0};

    sched_t q, d;

    logic          eng_start, eng_idle, eng_done, eng_ras_n, eng_cas_n;
    logic          timer_en, timer_clear, served, pend_any;
    logic [PW-1:0] pend;

    drs_cbr_engine #(
        .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .idle(eng_idle),
        .done(eng_done), .ras_n(eng_ras_n), .cas_n(eng_cas_n)
    );

    drs_ref_timer #(
        .INTERVAL(REF_INTERVAL), .MAX_PEND(MAX_PEND), .PW(PW)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(timer_en), .clear(timer_clear),
        .served(served), .pend(pend), .pend_any(pend_any)
    );

    assign timer_en = q.ready && (q.st == S_IDLE || q.st == S_REF);
    assign served   = eng_done && (q.st == S_REF);

    always_comb begin
        d           = q;
        eng_start   = 1'b0;
        timer_clear = 1'b0;
        case (q.st)
            S_PWR_WAIT: begin
                if (q.cnt == CW'(INIT_WAIT - 1)) begin
                    d.st  = S_INIT_REF;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_INIT_REF: begin
                eng_start = eng_idle && bus_grant;
                if (eng_done) begin
                    if (q.cnt == CW'(INIT_CYCLES - 1)) begin
                        d.st    = S_IDLE;
                        d.cnt   = '0;
                        d.ready = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_IDLE: begin
                if (sleep_req) begin
                    d.st  = S_PRE_BURST;
                    d.cnt = '0;
                end else if (pend_any) begin
                    d.st = S_REF;
                end
            end
            S_REF: begin
                eng_start = eng_idle && bus_grant && pend_any;
                if (eng_idle && !pend_any) d.st = S_IDLE;
            end
            S_PRE_BURST, S_POST_BURST: begin
                eng_start = eng_idle && bus_grant;
                if (eng_done) begin
                    if (q.cnt == CW'(ROWS - 1)) begin
                        d.cnt = '0;
                        if (q.st == S_PRE_BURST) begin
                            d.st = S_SELF_ENTER;
                        end else begin
                            d.st        = S_IDLE;
                            d.ack       = 1'b0;
                            timer_clear = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_SELF_ENTER: begin
                if (q.cnt == CW'(T_CSR - 1)) begin
                    d.st  = S_SELF;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_SELF: begin
                if (q.cnt != CW'(SELF_HOLD)) d.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(SELF_HOLD - 1)) d.ack = 1'b1;
                if (q.cnt == CW'(SELF_HOLD) && !sleep_req) begin
                    d.st  = S_SELF_EXIT;
                    d.cnt = '0;
                end
            end
            S_SELF_EXIT: begin
                if (q.cnt == CW'(T_RPS - 1)) begin
                    d.st  = S_POST_BURST;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign bus_req   = !(q.st == S_PWR_WAIT || q.st == S_IDLE);
    assign ras_n     = (q.st == S_SELF) ? 1'b0 : eng_ras_n;
    assign cas_n     = (q.st == S_SELF || q.st == S_SELF_ENTER) ? 1'b0 : eng_cas_n;
    assign we_n      = 1'b1;
    assign init_done = q.ready;
    assign sleep_ack = q.ack;

endmodule

// File: rtl/drs_sched_checks.sv
module drs_sched_checks
    import drs_pkg::*;
#(
    parameter int MAX_PEND = 8,
    parameter int PW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          bus_req,
    input logic          bus_grant,
    input logic          init_done,
    input logic          sleep_ack,
    input logic          eng_busy,
    input logic [PW-1:0] pend,
    input sched_st_e     st
);

    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PWR_WAIT) |-> (ras_n && cas_n && !bus_req)); // R1

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done) |-> init_done); // R2

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R3

    AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> ($past(bus_grant) && $past(bus_req))); // R5

    AST_PEND_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(MAX_PEND)); // R7

    AST_ACK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> (!ras_n && !cas_n)); // R9

    AST_EXIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && $rose(cas_n)) |-> $past(sleep_ack)); // R9

endmodule

bind dram_refresh_sched drs_sched_checks #(.MAX_PEND(MAX_PEND), .PW(PW)) u_checks (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .bus_req(bus_req),
    .bus_grant(bus_grant), .init_done(init_done), .sleep_ack(sleep_ack),
    .eng_busy(!eng_idle), .pend(pend), .st(q.st)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;

    localparam int CLK_PERIOD   = 10;
    localparam int INIT_WAIT    = 200;
    localparam int INIT_CYCLES  = 8;
    localparam int ROWS         = 16;
    localparam int REF_INTERVAL = 100;
    localparam int MAX_PEND     = 8;
    localparam int T_CSR        = 1;
    localparam int T_CHR        = 2;
    localparam int T_RAS        = 4;
    localparam int T_RP         = 3;
    localparam int SELF_HOLD    = 60;
    localparam int T_RPS        = 5;
    localparam int WDOG         = 60000;
    localparam int CYC_LEN      = T_CSR + T_RAS + T_RP + 1;

    logic clk = 1'b0, rst_n = 1'b0, bus_grant = 1'b1, sleep_req = 1'b0;
    logic bus_req, ras_n, cas_n, we_n, init_done, sleep_ack;

    dram_refresh_sched #(
        .INIT_WAIT(INIT_WAIT), .INIT_CYCLES(INIT_CYCLES), .ROWS(ROWS),
        .REF_INTERVAL(REF_INTERVAL), .MAX_PEND(MAX_PEND), .T_CSR(T_CSR),
        .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP), .SELF_HOLD(SELF_HOLD), .T_RPS(T_RPS)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .sleep_req(sleep_req),
        .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .init_done(init_done), .sleep_ack(sleep_ack)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected below %0d", cyc, WDOG);
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

    // Behavioural pin monitor: measures strobe waveforms and counts cycles.
    int t_cas_fall = 0, t_ras_fall = 0, t_ras_rise = -1;
    int cbr_count = 0, self_count = 0, self_dur = 0, gap_at_fall = 0;
    int t_self_exit = 0, cbr_at_exit = 0;
    bit last_self = 1'b0;
    logic p_ras = 1'b1, p_cas = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cas && !cas_n) begin
                t_cas_fall = cyc;
                if (ras_n) begin
                    check(bus_grant && bus_req, "R5", int'(bus_grant), 1);
                    if (t_ras_rise >= 0) begin
                        if (last_self)
                            check(cyc - t_ras_rise >= T_RPS, "R10", cyc - t_ras_rise, T_RPS);
                        else
                            check(cyc - t_ras_rise >= T_RP, "R4", cyc - t_ras_rise, T_RP);
                    end
                end
            end
            if (p_ras && !ras_n) begin
                t_ras_fall = cyc;
                check(!cas_n && (cyc - t_cas_fall == T_CSR), "R3", cyc - t_cas_fall, T_CSR);
                check(we_n == 1'b1, "R3", int'(we_n), 1);
                gap_at_fall = (t_ras_rise >= 0) ? cyc - t_ras_rise : 0;
            end
            if (!p_cas && cas_n && !ras_n)
                check(cyc - t_ras_fall == T_CHR, "R3", cyc - t_ras_fall, T_CHR);
            if (!p_ras && ras_n) begin
                if (cyc - t_ras_fall == T_RAS) begin
                    cbr_count++;
                    last_self = 1'b0;
                end else begin
                    check(cyc - t_ras_fall > SELF_HOLD, "R9", cyc - t_ras_fall, SELF_HOLD + 1);
                    check(cas_n == 1'b1, "R10", int'(cas_n), 1);
                    self_count++;
                    self_dur    = cyc - t_ras_fall;
                    last_self   = 1'b1;
                    t_self_exit = cyc;
                    cbr_at_exit = cbr_count;
                end
                t_ras_rise = cyc;
            end
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 4000 && bus_req; i++) @(negedge clk);
    endtask

    initial begin
        int c0, c1, t0, bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet power-up pause
        bad = 0;
        for (int i = 0; i < INIT_WAIT - 2; i++) begin
            @(negedge clk);
            if (!ras_n || !cas_n || bus_req || init_done) bad++;
        end
        check(bad == 0, "R1", bad, 0);

        // R2: warm-up cycles then ready
        for (int i = 0; i < 2000 && !init_done; i++) @(negedge clk);
        check(init_done == 1'b1, "R2", int'(init_done), 1);
        check(cbr_count == INIT_CYCLES, "R2", cbr_count, INIT_CYCLES);

        // R6: steady distributed refresh
        c0 = cbr_count;
        bad = 0;
        for (int i = 0; i < 10 * REF_INTERVAL; i++) begin
            @(negedge clk);
            if (!init_done) bad++;
        end
        check(cbr_count - c0 >= 9 && cbr_count - c0 <= 11, "R6", cbr_count - c0, 10);
        check(bad == 0, "R2", bad, 0);

        // R7/R5: withhold the grant, credits saturate
        wait_idle();
        bus_grant = 1'b0;
        c0 = cbr_count;
        repeat (12 * REF_INTERVAL) @(negedge clk);
        check(cbr_count == c0, "R5", cbr_count - c0, 0);
        check(bus_req == 1'b1, "R7", int'(bus_req), 1);
        bus_grant = 1'b1;
        t0 = cyc;
        c1 = cbr_count;
        for (int i = 0; i < 2000 && bus_req; i++) @(negedge clk);
        check(cbr_count - c1 >= MAX_PEND && cbr_count - c1 <= MAX_PEND + 1, "R7",
              cbr_count - c1, MAX_PEND);
        check(cyc - t0 <= (MAX_PEND + 1) * CYC_LEN + 4, "R7", cyc - t0, (MAX_PEND + 1) * CYC_LEN + 4);

        // R8/R9/R10: full sleep cycle
        wait_idle();
        sleep_req = 1'b1;
        c0 = cbr_count;
        for (int i = 0; i < 3000 && !sleep_ack; i++) @(negedge clk);
        check(sleep_ack == 1'b1, "R9", int'(sleep_ack), 1);
        check(cbr_count - c0 == ROWS, "R8", cbr_count - c0, ROWS);
        check(gap_at_fall == T_RP + T_CSR, "R8", gap_at_fall, T_RP + T_CSR);
        check(cyc - t_ras_fall == SELF_HOLD, "R9", cyc - t_ras_fall, SELF_HOLD);
        check(!ras_n && !cas_n, "R9", int'({ras_n, cas_n}), 0);
        repeat (20) @(negedge clk);
        check(!ras_n && !cas_n && sleep_ack, "R9", int'({ras_n, cas_n}), 0);
        sleep_req = 1'b0;
        for (int i = 0; i < 3000 && sleep_ack; i++) @(negedge clk);
        check(sleep_ack == 1'b0, "R10", int'(sleep_ack), 0);
        check(self_count == 1, "R10", self_count, 1);
        check(cbr_count - cbr_at_exit == ROWS, "R10", cbr_count - cbr_at_exit, ROWS);

        // R9/R10: request withdrawn just after the strobes go low
        wait_idle();
        sleep_req = 1'b1;
        c0 = cbr_count;
        for (int i = 0; i < 3000 && !(cbr_count - c0 == ROWS && !ras_n && !cas_n); i++)
            @(negedge clk);
        repeat (3) @(negedge clk);
        sleep_req = 1'b0;
        check(sleep_ack == 1'b0, "R9", int'(sleep_ack), 0);
        for (int i = 0; i < 3000 && self_count < 2; i++) @(negedge clk);
        check(self_dur > SELF_HOLD, "R9", self_dur, SELF_HOLD + 1);
        for (int i = 0; i < 3000 && !(sleep_ack == 1'b0 && cbr_count - cbr_at_exit == ROWS); i++)
            @(negedge clk);
        check(cbr_count - cbr_at_exit == ROWS && !sleep_ack, "R10", cbr_count - cbr_at_exit, ROWS);

        // R6: refresh resumes after self refresh
        c0 = cbr_count;
        repeat (3 * REF_INTERVAL + 20) @(negedge clk);
        check(cbr_count - c0 >= 2 && cbr_count - c0 <= 4, "R6", cbr_count - c0, 3);

        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule